// File: doc/BRIEF.md
# Keyboard Controller Command Processor

This block is the command engine of a keyboard controller. It sits behind a byte-wide host bus with two write strobes: one for the command port and one for the data port. A byte on the command port is decoded as a controller command in a single cycle. Some commands answer by pushing a byte into the keyboard response queue. Some edit the mode, status or output-port registers. Some only arm a pending parameter write, which then decides where the next data-port byte goes.

The output port drives the A20 gate line. A one-cycle system-reset request pulse comes from reset-class commands or from clearing bit 0 of the output port. The mode register drives a scan-code translation enable. Serial line handling and the devices' own command sets live elsewhere. This block only forwards bytes to those devices with a write strobe.

Every effect appears on the outputs one clock after the strobe that caused it. All strobe outputs are single-cycle pulses.

Top module: `kbc_cmd_proc`

## Requirements
- R1: After a synchronous reset, mode_q is 0x03, status_q is 0x18, outport_q is 0xCF, a20_gate is 1, xlat_en is 0, and all strobe outputs are low.
- R2: Certain command bytes push one response byte into the keyboard queue and do nothing else, except where noted. 0x20 pushes mode_q. 0xD0 pushes outport_q. 0xC0 pushes 0x80. 0xA9 and 0xAB each push 0x00. 0xAA pushes 0x55 and also sets status bit 2.
- R3: Command bytes 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 only arm a pending parameter write. They produce no strobe and no register change.
- R4: A data-port byte is routed by the pending parameter write:
  - 0x60 loads mode_q and sets xlat_en from bit 6 of the byte.
  - 0xD2 pushes the byte to the keyboard queue.
  - 0xD3 pushes it to the auxiliary queue.
  - 0xD1 writes the output port.
  - 0xD4 forwards it to the auxiliary device.
  - With nothing pending, the byte is forwarded to the keyboard device.
  - Every data write clears the pending state.
- R5: A command byte whose upper nibble is 0xF is folded before decode. With bit 0 clear it gives one sys_rst_req pulse. With bit 0 set it does nothing. Neither case raises bad_cmd.
- R6: Command 0xA7 sets mode bit 5 and 0xA8 clears it. Command 0xAD sets mode bit 4 and 0xAE clears it. No other mode bit changes.
- R7: Command 0xDF sets output-port bit 1 and raises a20_gate. Command 0xDD clears that bit and lowers a20_gate. a20_gate always equals outport_q bit 1.
- R8: An output-port write (pending 0xD1) stores the whole byte and drives a20_gate from bit 1. It produces a sys_rst_req pulse when bit 0 of the byte is 0.
- R9: Any other command byte changes no register and no pending state, and raises bad_cmd for one cycle.
- R10: A cycle with both cmd_we and data_we high executes the command only. The data byte is dropped and does not clear the pending state.
- R11: Outputs respond on the clock edge that samples the strobe. Every strobe output falls again one cycle later if no new strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command-port write strobe |
| data_we | input | 1 | Data-port write strobe |
| wr_byte | input | 8 | Byte written by the host |
| kbd_q_push | output | 1 | Push strobe into keyboard response queue |
| kbd_q_byte | output | 8 | Byte pushed into keyboard queue |
| aux_q_push | output | 1 | Push strobe into auxiliary response queue |
| aux_q_byte | output | 8 | Byte pushed into auxiliary queue |
| kbd_dev_we | output | 1 | Forward strobe to keyboard device |
| aux_dev_we | output | 1 | Forward strobe to auxiliary device |
| dev_byte | output | 8 | Byte forwarded to a device |
| mode_q | output | 8 | Mode register |
| status_q | output | 8 | Status register |
| outport_q | output | 8 | Output port register |
| a20_gate | output | 1 | A20 gate line |
| xlat_en | output | 1 | Scan-code translation enable |
| sys_rst_req | output | 1 | One-cycle system-reset request |
| bad_cmd | output | 1 | One-cycle unrecognised-command strobe |

## Verification
A command-port write and a data-port write can land in the same cycle, and the block must pick one meaning for that cycle. The bench provokes this directly: it arms a parameter command, then strobes both ports together. It also mixes such collisions into the random stream. The check is that only the command's effects show, that no device forward or data-side queue push occurs, and that the next lone data byte is still routed by the command that won the collision.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    // bit positions the decoder and neighbours rely on
    localparam int MB_KDIS  = 4;
    localparam int MB_ADIS  = 5;
    localparam int MB_XLAT  = 6;
    localparam int SB_SYS   = 2;
    localparam int OB_NRST  = 0;
    localparam int OB_GATE  = 1;

    localparam byte_t MODE_INIT = 8'h03;
    localparam byte_t STAT_INIT = 8'h18;
    localparam byte_t OUTP_INIT = 8'hCF;

    // command codes
    localparam byte_t C_RD_MODE  = 8'h20;
    localparam byte_t C_WR_MODE  = 8'h60;
    localparam byte_t C_ADIS     = 8'hA7;
    localparam byte_t C_AEN      = 8'hA8;
    localparam byte_t C_ATEST    = 8'hA9;
    localparam byte_t C_SELF     = 8'hAA;
    localparam byte_t C_KTEST    = 8'hAB;
    localparam byte_t C_KDIS     = 8'hAD;
    localparam byte_t C_KEN      = 8'hAE;
    localparam byte_t C_RD_IN    = 8'hC0;
    localparam byte_t C_RD_OUT   = 8'hD0;
    localparam byte_t C_WR_OUT   = 8'hD1;
    localparam byte_t C_WR_KQ    = 8'hD2;
    localparam byte_t C_WR_AQ    = 8'hD3;
    localparam byte_t C_WR_ADEV  = 8'hD4;
    localparam byte_t C_GATE_OFF = 8'hDD;
    localparam byte_t C_GATE_ON  = 8'hDF;
    localparam byte_t C_SYSRST   = 8'hFE;
    localparam byte_t C_NOP      = 8'hFF;

    localparam byte_t SELF_OK  = 8'h55;
    localparam byte_t INPORT_V = 8'h80;

    typedef enum logic [2:0] {
        PW_NONE, PW_MODE, PW_OUTP, PW_KQ, PW_AQ, PW_ADEV
    } pend_e;

    typedef struct packed {
        byte_t mode;
        byte_t stat;
        byte_t outp;
        logic  gate;
        logic  xlat;
        pend_e pend;
    } ctl_state_t;

    typedef struct packed {
        logic  kq;
        byte_t kq_b;
        logic  aq;
        byte_t aq_b;
        logic  kdev;
        logic  adev;
        byte_t dev_b;
        logic  rreq;
        logic  bad;
    } strb_t;

    typedef struct packed {
        ctl_state_t st;
        strb_t      sb;
    } step_t;

    function automatic byte_t fold_cmd(byte_t c);
        if (c[BYTE_W-1:BYTE_W-4] == 4'hF)
            return c[0] ? C_NOP : C_SYSRST;
        return c;
    endfunction

    function automatic ctl_state_t init_state();
        ctl_state_t s;
        s.mode = MODE_INIT;
        s.stat = STAT_INIT;
        s.outp = OUTP_INIT;
        s.gate = OUTP_INIT[OB_GATE];
        s.xlat = MODE_INIT[MB_XLAT];
        s.pend = PW_NONE;
        return s;
    endfunction

endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
    import kbc_pkg::*;
(
    input  ctl_state_t cur,
    input  byte_t      code,
    output step_t      step
);
    byte_t fc;

    always_comb begin
        fc = fold_cmd(code);
        step.st = cur;
        step.sb = '0;
        case (fc)
            C_RD_MODE: begin step.sb.kq = 1'b1; step.sb.kq_b = cur.mode; end
            C_WR_MODE:  step.st.pend = PW_MODE;
            C_WR_OUT:   step.st.pend = PW_OUTP;
            C_WR_KQ:    step.st.pend = PW_KQ;
            C_WR_AQ:    step.st.pend = PW_AQ;
            C_WR_ADEV:  step.st.pend = PW_ADEV;
            C_ADIS:     step.st.mode[MB_ADIS] = 1'b1;
            C_AEN:      step.st.mode[MB_ADIS] = 1'b0;
            C_KDIS:     step.st.mode[MB_KDIS] = 1'b1;
            C_KEN:      step.st.mode[MB_KDIS] = 1'b0;
            C_ATEST, C_KTEST: begin
                step.sb.kq = 1'b1; step.sb.kq_b = '0;
            end
            C_SELF: begin
                step.st.stat[SB_SYS] = 1'b1;
                step.sb.kq = 1'b1; step.sb.kq_b = SELF_OK;
            end
            C_RD_IN:  begin step.sb.kq = 1'b1; step.sb.kq_b = INPORT_V; end
            C_RD_OUT: begin step.sb.kq = 1'b1; step.sb.kq_b = cur.outp; end
            C_GATE_ON: begin
                step.st.outp[OB_GATE] = 1'b1; step.st.gate = 1'b1;
            end
            C_GATE_OFF: begin
                step.st.outp[OB_GATE] = 1'b0; step.st.gate = 1'b0;
            end
            C_SYSRST: step.sb.rreq = 1'b1;
            C_NOP:    ;
            default:  step.sb.bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/kbc_data_route.sv
module kbc_data_route
    import kbc_pkg::*;
(
    input  ctl_state_t cur,
    input  byte_t      din,
    output step_t      step
);
    always_comb begin
        step.st = cur;
        step.st.pend = PW_NONE;
        step.sb = '0;
        case (cur.pend)
            PW_NONE: begin step.sb.kdev = 1'b1; step.sb.dev_b = din; end
            PW_MODE: begin
                step.st.mode = din;
                step.st.xlat = din[MB_XLAT];
            end
            PW_OUTP: begin
                step.st.outp = din;
                step.st.gate = din[OB_GATE];
                step.sb.rreq = ~din[OB_NRST];
            end
            PW_KQ:   begin step.sb.kq = 1'b1; step.sb.kq_b = din; end
            PW_AQ:   begin step.sb.aq = 1'b1; step.sb.aq_b = din; end
            PW_ADEV: begin step.sb.adev = 1'b1; step.sb.dev_b = din; end
            default: ;
        endcase
    end
endmodule

// File: rtl/kbc_cmd_proc.sv
module kbc_cmd_proc
    import kbc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_we,
    input  logic        data_we,
    input  logic [7:0]  wr_byte,
    output logic        kbd_q_push,
    output logic [7:0]  kbd_q_byte,
    output logic        aux_q_push,
    output logic [7:0]  aux_q_byte,
    output logic        kbd_dev_we,
    output logic        aux_dev_we,
    output logic [7:0]  dev_byte,
    output logic [7:0]  mode_q,
    output logic [7:0]  status_q,
    output logic [7:0]  outport_q,
    output logic        a20_gate,
    output logic        xlat_en,
    output logic        sys_rst_req,
    output logic        bad_cmd
);
    ctl_state_t cur_q, nxt;
    strb_t      sb_q, sb_n;
    step_t      cstep, dstep;

    kbc_cmd_decode u_dec (.cur(cur_q), .code(wr_byte), .step(cstep));
    kbc_data_route u_rte (.cur(cur_q), .din(wr_byte), .step(dstep));

    // command port wins a shared cycle; the data byte is dropped
    always_comb begin
        nxt  = cur_q;
        sb_n = '0;
        if (cmd_we) begin
            nxt  = cstep.st;
            sb_n = cstep.sb;
        end else if (data_we) begin
            nxt  = dstep.st;
            sb_n = dstep.sb;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= init_state();
            sb_q  <= '0;
        end else begin
            cur_q <= nxt;
            sb_q  <= sb_n;
        end
    end

    assign kbd_q_push  = sb_q.kq;
    assign kbd_q_byte  = sb_q.kq_b;
    assign aux_q_push  = sb_q.aq;
    assign aux_q_byte  = sb_q.aq_b;
    assign kbd_dev_we  = sb_q.kdev;
    assign aux_dev_we  = sb_q.adev;
    assign dev_byte    = sb_q.dev_b;
    assign sys_rst_req = sb_q.rreq;
    assign bad_cmd     = sb_q.bad;
    assign mode_q      = cur_q.mode;
    assign status_q    = cur_q.stat;
    assign outport_q   = cur_q.outp;
    assign a20_gate    = cur_q.gate;
    assign xlat_en     = cur_q.xlat;
endmodule

// File: rtl/kbc_cmd_proc_chk.sv
module kbc_cmd_proc_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_we,
    input logic       data_we,
    input logic [7:0] wr_byte,
    input logic       kbd_q_push,
    input logic       aux_q_push,
    input logic       kbd_dev_we,
    input logic       aux_dev_we,
    input logic [7:0] mode_q,
    input logic [7:0] status_q,
    input logic [7:0] outport_q,
    input logic       a20_gate,
    input logic       sys_rst_req,
    input logic       bad_cmd
);
    // R7
    gate_tracks_port_chk: assert property (@(posedge clk) disable iff (rst)
        a20_gate == outport_q[1]);

    // R5
    rst_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |=> !sys_rst_req);

    // R9
    bad_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
        bad_cmd |-> (mode_q == $past(mode_q)) && (status_q == $past(status_q))
                    && (outport_q == $past(outport_q)));

    // R3
    arm_is_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && wr_byte == 8'h60) |=> !kbd_q_push && !aux_q_push
            && !kbd_dev_we && !aux_dev_we && !bad_cmd && $stable(mode_q));

    // R10
    collide_drops_data_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && data_we) |=> !kbd_dev_we && !aux_dev_we && !aux_q_push);

    // R11
    push_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (kbd_q_push || aux_q_push || bad_cmd) |-> $past(cmd_we || data_we));
endmodule

bind kbc_cmd_proc kbc_cmd_proc_chk u_chk (.*);

// File: tb/tb_kbc_cmd_proc.sv
`timescale 1ns/1ps
module tb_kbc_cmd_proc;
    logic clk = 1'b0, rst = 1'b1;
    logic cmd_we = 1'b0, data_we = 1'b0;
    logic [7:0] wr_byte = '0;
    logic kbd_q_push, aux_q_push, kbd_dev_we, aux_dev_we, a20_gate, xlat_en;
    logic sys_rst_req, bad_cmd;
    logic [7:0] kbd_q_byte, aux_q_byte, dev_byte, mode_q, status_q, outport_q;

    int n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    kbc_cmd_proc dut (.*);

    // reference state
    logic [7:0] em, es, eo, ep;
    logic eg, ex;
    logic ekp, eap, ekd, ead, err, ebad;
    logic [7:0] ekb, eab, edb;
    string tag;

    task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk("kbd_q_push", {7'd0, kbd_q_push}, {7'd0, ekp});
        if (ekp) chk("kbd_q_byte", kbd_q_byte, ekb);
        chk("aux_q_push", {7'd0, aux_q_push}, {7'd0, eap});
        if (eap) chk("aux_q_byte", aux_q_byte, eab);
        chk("kbd_dev_we", {7'd0, kbd_dev_we}, {7'd0, ekd});
        chk("aux_dev_we", {7'd0, aux_dev_we}, {7'd0, ead});
        if (ekd || ead) chk("dev_byte", dev_byte, edb);
        chk("sys_rst_req", {7'd0, sys_rst_req}, {7'd0, err});
        chk("bad_cmd", {7'd0, bad_cmd}, {7'd0, ebad});
        chk("mode_q", mode_q, em);
        chk("status_q", status_q, es);
        chk("outport_q", outport_q, eo);
        chk("a20_gate", {7'd0, a20_gate}, {7'd0, eg});
        chk("xlat_en", {7'd0, xlat_en}, {7'd0, ex});
    endtask

    task automatic clr_strb();
        ekp = 0; eap = 0; ekd = 0; ead = 0; err = 0; ebad = 0;
        ekb = 0; eab = 0; edb = 0;
    endtask

    function automatic string cmd_tag(logic [7:0] v);
        if (v[7:4] == 4'hF) return "R5";
        case (v)
            8'h20, 8'hA9, 8'hAA, 8'hAB, 8'hC0, 8'hD0: return "R2";
            8'h60, 8'hD1, 8'hD2, 8'hD3, 8'hD4: return "R3";
            8'hA7, 8'hA8, 8'hAD, 8'hAE: return "R6";
            8'hDD, 8'hDF: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic model(bit c, bit d, logic [7:0] v);
        logic [7:0] f;
        clr_strb();
        if (c) begin
            f = (v[7:4] == 4'hF) ? (v[0] ? 8'hFF : 8'hFE) : v;
            case (f)
                8'h20: begin ekp = 1; ekb = em; end
                8'h60, 8'hD1, 8'hD2, 8'hD3, 8'hD4: ep = f;
                8'hA7: em[5] = 1;
                8'hA8: em[5] = 0;
                8'hAD: em[4] = 1;
                8'hAE: em[4] = 0;
                8'hA9, 8'hAB: begin ekp = 1; ekb = 8'h00; end
                8'hAA: begin es[2] = 1; ekp = 1; ekb = 8'h55; end
                8'hC0: begin ekp = 1; ekb = 8'h80; end
                8'hD0: begin ekp = 1; ekb = eo; end
                8'hDF: begin eo[1] = 1; eg = 1; end
                8'hDD: begin eo[1] = 0; eg = 0; end
                8'hFE: err = 1;
                8'hFF: ;
                default: ebad = 1;
            endcase
        end else if (d) begin
            case (ep)
                8'h60: begin em = v; ex = v[6]; end
                8'hD1: begin eo = v; eg = v[1]; err = ~v[0]; end
                8'hD2: begin ekp = 1; ekb = v; end
                8'hD3: begin eap = 1; eab = v; end
                8'hD4: begin ead = 1; edb = v; end
                default: begin ekd = 1; edb = v; end
            endcase
            ep = 8'h00;
        end
    endtask

    task automatic apply(bit c, bit d, logic [7:0] v);
        @(negedge clk);
        cmd_we = c; data_we = d; wr_byte = v;
        model(c, d, v);
        tag = (c && d) ? "R10" : (c ? cmd_tag(v) : "R4");
        if (!c && d && ep == 8'h00 && err) tag = "R8";
        @(negedge clk);
        cmd_we = 0; data_we = 0; wr_byte = $urandom;
        check_all();
        // R11: strobes drop after one idle cycle
        @(negedge clk);
        clr_strb();
        tag = "R11";
        check_all();
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    logic [7:0] codes [0:23];
    initial begin
        void'($urandom(32'd20240917));
        codes = '{8'h20, 8'h60, 8'hD1, 8'hD2, 8'hD3, 8'hD4, 8'hA7, 8'hA8,
                  8'hA9, 8'hAA, 8'hAB, 8'hAD, 8'hAE, 8'hC0, 8'hD0, 8'hDD,
                  8'hDF, 8'hF0, 8'hF3, 8'hFE, 8'hFF, 8'hA1, 8'h00, 8'h5A};
        em = 8'h03; es = 8'h18; eo = 8'hCF; eg = 1; ex = 0; ep = 0;
        clr_strb();
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        tag = "R1";
        check_all();

        // directed corner cases
        apply(1, 0, 8'h20);                       // R2 read mode
        apply(1, 0, 8'h60); apply(0, 1, 8'h47);   // R4 mode load, xlat on
        apply(1, 0, 8'hA7); apply(1, 0, 8'hA8);   // R6
        apply(1, 0, 8'hAD); apply(1, 0, 8'hAE);
        apply(1, 0, 8'hAA);                       // R2 self test
        apply(1, 0, 8'hDD); apply(1, 0, 8'hD0);   // R7 then read port
        apply(1, 0, 8'hDF);
        apply(1, 0, 8'hD1); apply(0, 1, 8'h00);   // R8 reset request, gate low
        apply(1, 0, 8'hD1); apply(0, 1, 8'h03);   // R8 no request
        apply(1, 0, 8'hF0); apply(1, 0, 8'hF1);   // R5 folding
        apply(1, 0, 8'hA1);                       // R9 unknown
        apply(0, 1, 8'h3C);                       // R4 keyboard device
        apply(1, 0, 8'hD3); apply(0, 1, 8'h9C);   // R4 aux queue
        apply(1, 0, 8'hD4); apply(0, 1, 8'h12);   // R4 aux device
        apply(1, 0, 8'hD2); apply(1, 1, 8'h60);   // R10 collision
        apply(0, 1, 8'h22);                       // R10 pending survives

        for (int i = 0; i < 600; i++) begin
            int r;
            logic [7:0] v;
            r = $urandom % 10;
            if (r < 6) v = codes[$urandom % 24];
            else v = $urandom;
            if (r < 6)      apply(1, 0, v);
            else if (r < 9) apply(0, 1, v);
            else            apply(1, 1, codes[$urandom % 24]);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule